// File: doc/BRIEF.md
# DRAM Page-Mode Burst Read Sequencer

This block runs one four-beat page-mode read from a DRAM bank with a 32-bit data bus. When a request is accepted, the sequencer gives one precharge cycle. It then gives one row cycle with RAS asserted, followed by four column beats of one clock each. The column beats are issued in target-first wrap order. Each beat strobes the CAS lines of the active byte lanes for the first half of the clock and holds the output enable low. One data word is captured per beat. A done pulse then presents all four captured words and a bus-error flag.

The request side is a valid/ready stream. `req_ready` is high only while the sequencer is idle. A request transfers on a rising clock edge where both `req_valid` and `req_ready` are high. The address, bus width, mux mode and latch option are sampled on that edge and held for the whole transfer. A requester that keeps `req_valid` high while the block is busy is stalled and its inputs are not looked at. The response side has no back-pressure. `rsp_valid` is high for exactly one cycle, and the consumer must take `rsp_data` and `rsp_err` in that cycle.

The address pins can run in two modes. In the first, the block multiplexes row and column onto the pins itself. In the second, the full word address is driven and an external multiplexer does the split. On byte and half-word buses the two upper byte-select pins carry the two low byte-address bits.

Top module: `dbr_burst_read`

## Requirements
- R1: `req_ready` is 1 only in idle (including during reset). A request is taken on an edge where `req_valid` and `req_ready` are both 1. While a transfer is in flight, `req_valid` and every request input are ignored.
- R2: After acceptance, the cycles are as follows. One precharge cycle (ras_n=1, oe_n=1). One row cycle (ras_n=0, oe_n=1). Four column beats (ras_n=0). One done cycle in which ras_n=1 and rsp_valid=1. Then idle.
- R3: Width code `req_width` is 00 for byte, 01 for half-word and 10 for word. The beat unit is 1, 2 or 4 bytes. For unit index u = addr / unit, beat k uses unit (u with its low two bits replaced by (u+k) mod 4). The word captured in beat k appears at `rsp_data[32k+31:32k]`.
- R4: Internal mux (`req_ext_mux`=0). With word address wa = beat byte address / 4, the pins carry {wa[WA_W-1:2*COL_W], COL_W zeros, F}. F is wa[2*COL_W-1:COL_W] in the precharge and row cycles, and wa[COL_W-1:0] in each column beat. In idle and done cycles the pins are 0.
- R5: External mux (`req_ext_mux`=1). The pins carry the full word address wa of the current beat, using beat 0 in the precharge and row cycles. The value therefore does not change from the row cycle to the first beat.
- R6: On byte and half-word buses, from precharge through the last beat, `bytesel_n[2]` carries bit 1 and `bytesel_n[3]` carries bit 0 of the current beat's byte address.
- R7: `bytesel_n[1:0]` is always 11. `bytesel_n[3:2]` is 11 on a word bus and in idle and done cycles.
- R8: In each column beat, `cas_n[i]` is 0 during the first half of the clock for every active lane i and 1 in the second half. Active lanes are: all on a word bus; lanes {2h, 2h+1} for a half-word at byte-address bit 1 equal to h; lane b for a byte at byte-address bits [1:0] equal to b. Outside the column beats, cas_n is 1111.
- R9: oe_n is 0 in exactly the four column beats. we_n is 1 at all times.
- R10: With `req_late_latch`=0, each beat's word is the value of `mem_dq` at the rising clock edge that ends the beat.
- R11: With `req_late_latch`=1, each beat's word is the value of `mem_dq` at the rising edge of CAS, which is the falling clock edge in the middle of the beat.
- R12: `mem_err` is sampled at the same point as the data. `rsp_err` is 1 in the done cycle if it was high on any beat of that transfer, and it starts clear for each transfer.
- R13: rsp_valid is a single-cycle pulse in the cycle after the fourth beat. Inputs changed after acceptance do not alter the running transfer.
- R14: Width code 11 behaves exactly as word width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | WA_W+2 | Byte address of the target unit |
| req_width | input | 2 | Bus width code (00 byte, 01 half, 10/11 word) |
| req_ext_mux | input | 1 | 1 = pins carry full word address |
| req_late_latch | input | 1 | 1 = capture on CAS rising edge |
| mem_dq | input | 32 | DRAM read data |
| mem_err | input | 1 | Per-beat error indication |
| mem_addr | output | WA_W | Address pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 4 | Column strobes per byte lane, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low (held inactive) |
| bytesel_n | output | 4 | Byte-select pins; upper two carry low address bits on narrow buses |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | 128 | Four captured words, beat 0 in the low word |
| rsp_err | output | 1 | Bus error for the finished transfer |

## Verification
The bench starts bursts at non-zero units, so a sequencer that counts upward without wrapping would show wrong column pins and wrong word order. On `mem_dq` it drives one value before the mid-cycle falling edge and a different value after it. A design that latched at the wrong point for either option would return the other value. Byte and half-word bursts check the lane decode and the byte-select address bits, and an external-mux burst checks that the address stays the same from the row cycle into the first beat. The bench also sends an error on a single beat followed by a clean transfer, which catches a sticky error flag. It holds a second request during a busy transfer, which catches a design that accepts it early or lets it disturb the running burst.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int BEATS  = 4;
  localparam int BEAT_W = $clog2(BEATS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROW,
    ST_COL,
    ST_DONE
  } dbr_state_e;

  typedef enum logic [1:0] {
    WD_BYTE = 2'b00,
    WD_HALF = 2'b01,
    WD_WORD = 2'b10,
    WD_WIDE = 2'b11
  } dbr_width_e;

  // log2 of the beat unit in bytes; codes 10 and 11 are both full word
  function automatic logic [1:0] unit_shift(input logic [1:0] wd);
    case (wd)
      WD_BYTE: unit_shift = 2'd0;
      WD_HALF: unit_shift = 2'd1;
      default: unit_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/dbr_seq.sv
module dbr_seq
  import dbr_pkg::*;
#(
  parameter int BA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BA_W-1:0]   req_addr,
  input  logic [1:0]        req_width,
  input  logic              req_ext_mux,
  input  logic              req_late_latch,
  output logic              req_ready,
  output dbr_state_e        state,
  output logic [BEAT_W-1:0] beat,
  output logic              strobe_low,
  output logic [BA_W-1:0]   cur_addr,
  output logic [1:0]        cur_width,
  output logic              cur_ext,
  output logic              cur_late
);
  logic ph;
  logic ph_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      beat      <= '0;
      ph        <= 1'b0;
      cur_addr  <= '0;
      cur_width <= 2'b00;
      cur_ext   <= 1'b0;
      cur_late  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr  <= req_addr;
            cur_width <= req_width;
            cur_ext   <= req_ext_mux;
            cur_late  <= req_late_latch;
            state     <= ST_PRE;
          end
        end
        ST_PRE: state <= ST_ROW;
        ST_ROW: begin
          state <= ST_COL;
          beat  <= '0;
          ph    <= ~ph;
        end
        ST_COL: begin
          if (beat == BEAT_W'(BEATS - 1)) begin
            state <= ST_DONE;
          end else begin
            beat <= beat + 1'b1;
            ph   <= ~ph;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // falling-edge copy of the beat phase: strobe low only in the first half
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ph_mid <= 1'b0;
    else        ph_mid <= ph;
  end

  assign req_ready  = (state == ST_IDLE);
  assign strobe_low = (state == ST_COL) && (ph != ph_mid);
endmodule

// File: rtl/dbr_addr.sv
module dbr_addr
  import dbr_pkg::*;
#(
  parameter int WA_W  = 20,
  parameter int COL_W = 8
) (
  input  dbr_state_e          state,
  input  logic [BEAT_W-1:0]   beat,
  input  logic [WA_W+1:0]     base,
  input  logic [1:0]          width,
  input  logic                ext_mux,
  output logic [WA_W-1:0]     mem_addr,
  output logic [LANES-1:0]    lanes,
  output logic [3:0]          bytesel_n
);
  localparam int BA_W = WA_W + 2;
  localparam int HI_W = WA_W - 2 * COL_W;

  logic [1:0]        sh;
  logic [BEAT_W-1:0] k;
  logic [BA_W-1:0]   unit_idx;
  logic [BA_W-1:0]   beat_unit;
  logic [BA_W-1:0]   beat_byte;
  logic [WA_W-1:0]   wa;
  logic              active;
  logic              narrow;
  logic [COL_W-1:0]  mux_field;

  always_comb begin
    sh        = unit_shift(width);
    k         = (state == ST_COL) ? beat : '0;
    unit_idx  = base >> sh;
    beat_unit = {unit_idx[BA_W-1:2], unit_idx[1:0] + k};
    beat_byte = beat_unit << sh;
    wa        = beat_byte[BA_W-1:2];
    active    = (state == ST_PRE) || (state == ST_ROW) || (state == ST_COL);
    narrow    = (width == WD_BYTE) || (width == WD_HALF);
    mux_field = (state == ST_COL) ? wa[COL_W-1:0] : wa[2*COL_W-1:COL_W];
  end

  generate
    if (HI_W > 0) begin : g_hi
      always_comb begin
        if (!active)      mem_addr = '0;
        else if (ext_mux) mem_addr = wa;
        else              mem_addr = {wa[WA_W-1:2*COL_W], {COL_W{1'b0}}, mux_field};
      end
    end else begin : g_nohi
      always_comb begin
        if (!active)      mem_addr = '0;
        else if (ext_mux) mem_addr = wa;
        else              mem_addr = {{COL_W{1'b0}}, mux_field};
      end
    end
  endgenerate

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      case (width)
        WD_BYTE: lanes[i] = (beat_byte[1:0] == 2'(i));
        WD_HALF: lanes[i] = ((i / 2) == int'(beat_byte[1]));
        default: lanes[i] = 1'b1;
      endcase
    end
  end

  assign bytesel_n = (active && narrow) ? {beat_byte[0], beat_byte[1], 2'b11} : 4'hF;
endmodule

// File: rtl/dbr_capture.sv
module dbr_capture
  import dbr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  dbr_state_e              state,
  input  logic [BEAT_W-1:0]       beat,
  input  logic                    late,
  input  logic [DATA_W-1:0]       mem_dq,
  input  logic                    mem_err,
  output logic [BEATS*DATA_W-1:0] rsp_data,
  output logic                    rsp_err
);
  logic [DATA_W-1:0] word_edge [BEATS];
  logic [DATA_W-1:0] word_mid  [BEATS];
  logic              err_edge;
  logic              err_mid;

  // capture on the clock edge closing each beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BEATS; b++) word_edge[b] <= '0;
      err_edge <= 1'b0;
    end else if (state == ST_PRE) begin
      err_edge <= 1'b0;
    end else if (state == ST_COL && !late) begin
      word_edge[beat] <= mem_dq;
      err_edge        <= err_edge | mem_err;
    end
  end

  // capture on the strobe rising edge, which is the mid-beat falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BEATS; b++) word_mid[b] <= '0;
      err_mid <= 1'b0;
    end else if (state == ST_PRE) begin
      err_mid <= 1'b0;
    end else if (state == ST_COL && late) begin
      word_mid[beat] <= mem_dq;
      err_mid        <= err_mid | mem_err;
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_out
    assign rsp_data[g*DATA_W +: DATA_W] = late ? word_mid[g] : word_edge[g];
  end

  assign rsp_err = late ? err_mid : err_edge;
endmodule

// File: rtl/dbr_burst_read.sv
module dbr_burst_read
  import dbr_pkg::*;
#(
  parameter int WA_W  = 20,
  parameter int COL_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [WA_W+1:0]         req_addr,
  input  logic [1:0]              req_width,
  input  logic                    req_ext_mux,
  input  logic                    req_late_latch,
  input  logic [DATA_W-1:0]       mem_dq,
  input  logic                    mem_err,
  output logic [WA_W-1:0]         mem_addr,
  output logic                    ras_n,
  output logic [LANES-1:0]        cas_n,
  output logic                    oe_n,
  output logic                    we_n,
  output logic [3:0]              bytesel_n,
  output logic                    rsp_valid,
  output logic [BEATS*DATA_W-1:0] rsp_data,
  output logic                    rsp_err
);
  localparam int BA_W = WA_W + 2;

  dbr_state_e        state;
  logic [BEAT_W-1:0] beat;
  logic              strobe_low;
  logic [BA_W-1:0]   cur_addr;
  logic [1:0]        cur_width;
  logic              cur_ext;
  logic              cur_late;
  logic [LANES-1:0]  lanes;

  dbr_seq #(.BA_W(BA_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_width      (req_width),
    .req_ext_mux    (req_ext_mux),
    .req_late_latch (req_late_latch),
    .req_ready      (req_ready),
    .state          (state),
    .beat           (beat),
    .strobe_low     (strobe_low),
    .cur_addr       (cur_addr),
    .cur_width      (cur_width),
    .cur_ext        (cur_ext),
    .cur_late       (cur_late)
  );

  dbr_addr #(.WA_W(WA_W), .COL_W(COL_W)) u_addr (
    .state     (state),
    .beat      (beat),
    .base      (cur_addr),
    .width     (cur_width),
    .ext_mux   (cur_ext),
    .mem_addr  (mem_addr),
    .lanes     (lanes),
    .bytesel_n (bytesel_n)
  );

  dbr_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .beat     (beat),
    .late     (cur_late),
    .mem_dq   (mem_dq),
    .mem_err  (mem_err),
    .rsp_data (rsp_data),
    .rsp_err  (rsp_err)
  );

  assign ras_n     = !((state == ST_ROW) || (state == ST_COL));
  assign oe_n      = (state != ST_COL);
  assign we_n      = 1'b1;
  assign cas_n     = ~(lanes & {LANES{strobe_low}});
  assign rsp_valid = (state == ST_DONE);
endmodule

// File: rtl/dbr_checker.sv
module dbr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       ras_n,
  input logic       oe_n,
  input logic       rsp_valid,
  input logic [3:0] cas_n
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && ras_n && oe_n)); // R1

  AST_ROW_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(ras_n && oe_n && !req_ready)); // R2

  AST_OE_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> ($past(!ras_n) && $past(oe_n))); // R9

  AST_OE_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> (rsp_valid && ras_n)); // R13

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R13

  AST_STROBE_EDGE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (cas_n == 4'hF)); // R8
endmodule

bind dbr_burst_read dbr_checker u_chk (.*);

// File: tb/dbr_burst_read_test.sv
module dbr_burst_read_test;
  localparam int CLK_P = 10;
  localparam logic [31:0] EARLY = 32'hE0E0_0000;
  localparam logic [31:0] LATE  = 32'h0B0B_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [21:0]  req_addr = '0;
  logic [1:0]   req_width = 2'b10;
  logic         req_ext_mux = 1'b0;
  logic         req_late_latch = 1'b0;
  logic [31:0]  mem_dq = '0;
  logic         mem_err = 1'b0;
  logic [19:0]  mem_addr;
  logic         ras_n;
  logic [3:0]   cas_n;
  logic         oe_n;
  logic         we_n;
  logic [3:0]   bytesel_n;
  logic         rsp_valid;
  logic [127:0] rsp_data;
  logic         rsp_err;

  dbr_burst_read uut (.*);

  always #(CLK_P / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int err_beat = -1;

  // reference model: 0 idle, 1 precharge, 2 row, 3 column, 4 done
  int m_st = 0, m_beat = 0, m_ba = 0, m_bw = 2;
  bit m_ext = 0, m_late = 0, m_err = 0;
  logic [31:0] m_buf [4];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  function automatic int bbyte(int k);
    int s, u, bu;
    s  = (m_bw == 0) ? 0 : ((m_bw == 1) ? 1 : 2);
    u  = m_ba >> s;
    bu = (u & ~3) | ((u + k) & 3);
    return bu << s;
  endfunction

  function automatic int cur_k();
    return (m_st == 3) ? m_beat : 0;
  endfunction

  function automatic logic [19:0] exp_addr();
    int wa, hi, low;
    if (m_st == 0 || m_st == 4) return '0;
    wa = bbyte(cur_k()) >> 2;
    if (m_ext) return 20'(wa);
    hi  = wa >> 16;
    low = (m_st == 3) ? (wa & 255) : ((wa >> 8) & 255);
    return 20'((hi << 16) | low);
  endfunction

  function automatic logic [3:0] exp_bytesel();
    int b;
    if (m_st < 1 || m_st > 3 || m_bw >= 2) return 4'hF;
    b = bbyte(cur_k());
    return {1'(b & 1), 1'((b >> 1) & 1), 2'b11};
  endfunction

  function automatic logic [3:0] exp_cas_first();
    int b;
    if (m_st != 3) return 4'hF;
    b = bbyte(m_beat);
    if (m_bw >= 2) return 4'h0;
    if (m_bw == 1) return ((b & 2) != 0) ? 4'b0011 : 4'b1100;
    return ~(4'b0001 << (b & 3));
  endfunction

  task automatic model_step();
    case (m_st)
      0: if (req_valid) begin
           m_ba = int'(req_addr); m_bw = int'(req_width);
           m_ext = req_ext_mux; m_late = req_late_latch; m_err = 0; m_st = 1;
         end
      1: m_st = 2;
      2: begin m_st = 3; m_beat = 0; end
      3: begin
           m_buf[m_beat] = m_late ? (EARLY ^ 32'(cyc)) : (LATE ^ 32'(cyc));
           if (mem_err) m_err = 1;
           if (m_beat == 3) m_st = 4; else m_beat++;
         end
      default: m_st = 0;
    endcase
  endtask

  task automatic check_first();
    logic [127:0] ed;
    chk(req_ready == (m_st == 0), "R1 ready", 128'(req_ready), 128'(m_st == 0));
    chk(ras_n == !(m_st == 2 || m_st == 3), "R2 ras_n", 128'(ras_n), 128'(!(m_st == 2 || m_st == 3)));
    chk(oe_n == (m_st != 3), "R9 oe_n", 128'(oe_n), 128'(m_st != 3));
    chk(we_n == 1'b1, "R9 we_n", 128'(we_n), 128'(1));
    chk(mem_addr == exp_addr(), m_ext ? "R5 addr ext" : "R4 addr int", 128'(mem_addr), 128'(exp_addr()));
    chk(bytesel_n == exp_bytesel(), "R6 R7 bytesel", 128'(bytesel_n), 128'(exp_bytesel()));
    chk(cas_n == exp_cas_first(), "R8 R14 cas first half", 128'(cas_n), 128'(exp_cas_first()));
    chk(rsp_valid == (m_st == 4), "R13 done pulse", 128'(rsp_valid), 128'(m_st == 4));
    if (m_st == 4) begin
      ed = {m_buf[3], m_buf[2], m_buf[1], m_buf[0]};
      chk(rsp_data == ed, m_late ? "R3 R11 data" : "R3 R10 data", rsp_data, ed);
      chk(rsp_err == m_err, "R12 bus error", 128'(rsp_err), 128'(m_err));
    end
  endtask

  // clock-by-clock model update, memory data drive and comparison
  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n) m_st = 0; else model_step();
      cyc++;
      #1;
      mem_dq  = EARLY ^ 32'(cyc);
      mem_err = (m_st == 3 && m_beat == err_beat);
      #2 check_first();
      @(negedge clk);
      #1 mem_dq = LATE ^ 32'(cyc);
      #2 chk(cas_n == 4'hF, "R8 cas second half", 128'(cas_n), 128'hF);
    end
  end

  task automatic wait_accept();
    bit acc;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk);
    end while (!acc);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_req(input logic [21:0] a, input logic [1:0] w, input bit ext, input bit lt, input int eb);
    @(posedge clk); #1;
    req_addr = a; req_width = w; req_ext_mux = ext; req_late_latch = lt;
    err_beat = eb; req_valid = 1'b1;
    wait_accept();
  endtask

  task automatic wait_idle();
    while (m_st != 0) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R3 R4 R10: word bus, internal mux, start at word 2
    do_req(22'h2A_5B68, 2'b10, 0, 0, -1); wait_idle();
    // R11: same burst, late latch
    do_req(22'h2A_5B68, 2'b10, 0, 1, -1); wait_idle();
    // R5: external mux, start at word 1
    do_req(22'h13_C7A4, 2'b10, 1, 0, -1); wait_idle();
    // R6 R8: byte bus, start at byte 3
    do_req(22'h05_9E0B, 2'b00, 0, 1, -1); wait_idle();
    // R6 R8: half-word bus external, start at unit 3, wraps across words
    do_req(22'h3F_0036, 2'b01, 1, 0, -1); wait_idle();
    // R12: error on beat 2, then a clean transfer clears it
    do_req(22'h11_2230, 2'b10, 0, 0, 2); wait_idle();
    do_req(22'h11_2230, 2'b10, 0, 0, -1); wait_idle();
    do_req(22'h07_4404, 2'b00, 1, 1, 0); wait_idle();
    // R14: width code 11
    do_req(22'h26_AB1C, 2'b11, 0, 1, -1); wait_idle();
    // R1 R13: second request held while busy, changed inputs ignored
    do_req(22'h1D_6E48, 2'b10, 0, 0, -1);
    @(posedge clk); #1;
    req_addr = 22'h02_0102; req_width = 2'b01; req_ext_mux = 1; req_late_latch = 1;
    req_valid = 1'b1;
    wait_accept();
    wait_idle();
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule